// File: doc/BRIEF.md
# Double-to-Single Store Narrower

This block turns a 64-bit double-precision register image into the 32-bit single-precision word that a floating-point store writes to memory. The conversion does no arithmetic. It does not round, it raises no exception and it leaves no status behind. The result is chosen purely from the biased double exponent E, which is input bits 62:52:

- For large exponents the output is assembled from selected input bits.
- For exponents in the single-precision denormal window the output carries a right-shifted fraction.
- For anything smaller the output is a signed zero.

A store unit places a 64-bit value on `in_dbl` and pulses `in_valid`. One clock later, `out_valid` pulses and `out_sgl` holds the word to write. `out_sgl` keeps its value until the next valid input arrives. Because this path only moves bits, a single-precision word that the load path widened to double comes back unchanged.

Top module: `dp_to_sp_narrow`

## Requirements
- R1: `out_valid` equals the `in_valid` of the previous clock edge. While `rst_n` is low, `out_valid` is 0.
- R2: When E > 896, output bits 31:30 equal input bits 63:62 and output bits 29:0 equal input bits 58:29. For example, 0x3FF0000000000000 gives 0x3F800000.
- R3: Infinities, NaNs and finite values too large for single precision (any E > 896) use the same bit selection as R2. There is no saturation and no special case, so 0x7FF0000000000001 gives 0x7F800000.
- R4: When 874 <= E <= 896, output bit 31 is the input sign and bits 30:23 are zero. Bits 22:0 are the low 23 bits of the 53-bit value {1, input bits 51:0} shifted right by 926 - E. E = 896 with a zero fraction gives 0x00400000, and E = 874 gives 0x00000001.
- R5: When E < 874, which includes a true zero, the output is the input sign in bit 31 with bits 30:0 all zero.
- R6: Input bits dropped by the selection or by the shift never change the result. There is no rounding or sticky behaviour: 0x3FF000001FFFFFFF still gives 0x3F800000.
- R7: A cycle with `in_valid` low leaves `out_sgl` unchanged, whatever `in_dbl` holds.
- R8: Any 32-bit single word, widened to double by the load-side rule and then passed through this block, returns exactly as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | Strobe marking a double value on `in_dbl` |
| in_dbl | input | 64 | Double-precision register image |
| out_valid | output | 1 | Strobe, one clock after `in_valid` |
| out_sgl | output | 32 | Narrowed single-precision word, registered |

## Verification
The hardest corners to reach are the two edges of the denormal window:

- At E = 874 the 53-bit mantissa is shifted by the largest amount, 52, so only the hidden one survives.
- At E = 896 the shift is 30 and the hidden one lands in bit 22.

Random doubles almost never fall on these exponents. The stimulus therefore drives them directly, together with their neighbours 873 and 897 and with all-ones fractions that show whether the dropped bits are truly dropped. A further sweep widens single words of every exponent (including each single-bit denormal position) into doubles and feeds them through the block. Those doubles hit every E in the denormal window, and each output must equal the starting word.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

  // Double-precision image layout
  localparam int unsigned DBL_W      = 64;
  localparam int unsigned DBL_EXP_W  = 11;
  localparam int unsigned DBL_FRAC_W = DBL_W - DBL_EXP_W - 1;

  // Single-precision word layout
  localparam int unsigned SGL_W      = 32;
  localparam int unsigned SGL_EXP_W  = 8;
  localparam int unsigned SGL_FRAC_W = SGL_W - SGL_EXP_W - 1;

  // Mantissa with the hidden one, and the shift amount width
  localparam int unsigned MANT_W  = DBL_FRAC_W + 1;
  localparam int unsigned SHAMT_W = $clog2(MANT_W);

  // Biased-exponent thresholds that pick the narrowing path
  localparam int unsigned NORM_FLOOR   = 896;               // E above this: bit selection
  localparam int unsigned DENORM_FLOOR = NORM_FLOOR - SGL_FRAC_W + 1; // 874
  localparam int unsigned DENORM_BASE  = NORM_FLOOR + 30;   // shift = DENORM_BASE - E

  typedef enum logic [1:0] {
    PATH_ZERO   = 2'd0,
    PATH_DENORM = 2'd1,
    PATH_NORMAL = 2'd2
  } narrow_path_e;

  typedef struct packed {
    logic                  sign;
    logic [DBL_EXP_W-1:0]  exp;
    logic [DBL_FRAC_W-1:0] frac;
  } dbl_fields_t;

endpackage

// File: rtl/fpn_path_decode.sv
module fpn_path_decode
  import fpn_pkg::*;
(
  input  logic [DBL_EXP_W-1:0] exp_in,
  output narrow_path_e         path,
  output logic [SHAMT_W-1:0]   shamt
);

  localparam logic [DBL_EXP_W-1:0] NORM_FLOOR_E   = DBL_EXP_W'(NORM_FLOOR);
  localparam logic [DBL_EXP_W-1:0] DENORM_FLOOR_E = DBL_EXP_W'(DENORM_FLOOR);
  // The window is narrower than 2**SHAMT_W, so the shift is computed modulo that.
  localparam logic [SHAMT_W-1:0]   BASE_MOD       = SHAMT_W'(DENORM_BASE % (1 << SHAMT_W));

  always_comb begin
    path  = PATH_ZERO;
    shamt = '0;
    if (exp_in > NORM_FLOOR_E) begin
      path = PATH_NORMAL;
    end else if (exp_in >= DENORM_FLOOR_E) begin
      path  = PATH_DENORM;
      shamt = BASE_MOD - exp_in[SHAMT_W-1:0];
    end
  end

endmodule

// File: rtl/fpn_rshift.sv
module fpn_rshift #(
  parameter int unsigned IN_W  = 53,
  parameter int unsigned AMT_W = 6,
  parameter int unsigned OUT_W = 23
) (
  input  logic [IN_W-1:0]  din,
  input  logic [AMT_W-1:0] amt,
  output logic [OUT_W-1:0] dout
);

  logic [IN_W-1:0] stage [AMT_W+1];

  assign stage[0] = din;

  // Logarithmic shifter: stage g shifts by 2**g when amount bit g is set.
  for (genvar g = 0; g < AMT_W; g++) begin : g_stage
    assign stage[g+1] = amt[g] ? (stage[g] >> (1 << g)) : stage[g];
  end

  // Only the low bits are kept; shifted-out bits are discarded.
  assign dout = OUT_W'(stage[AMT_W]);

endmodule

// File: rtl/fpn_pack.sv
module fpn_pack
  import fpn_pkg::*;
(
  input  dbl_fields_t            fields,
  input  narrow_path_e           path,
  input  logic [SGL_FRAC_W-1:0]  denorm_frac,
  output logic [SGL_W-1:0]       word
);

  logic [SGL_W-1:0] normal_word;
  logic [SGL_W-1:0] small_word;

  // Bit selection: sign, exponent MSB, low exponent bits, top fraction bits.
  assign normal_word = {fields.sign,
                        fields.exp[DBL_EXP_W-1],
                        fields.exp[SGL_EXP_W-2:0],
                        fields.frac[DBL_FRAC_W-1 -: SGL_FRAC_W]};

  assign small_word = {fields.sign, {SGL_EXP_W{1'b0}}, denorm_frac};

  always_comb begin
    unique case (path)
      PATH_NORMAL: word = normal_word;
      PATH_DENORM: word = small_word;
      default:     word = {fields.sign, {(SGL_W-1){1'b0}}};
    endcase
  end

endmodule

// File: rtl/dp_to_sp_narrow.sv
module dp_to_sp_narrow
  import fpn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DBL_W-1:0] in_dbl,
  output logic             out_valid,
  output logic [SGL_W-1:0] out_sgl
);

  dbl_fields_t             fields;
  narrow_path_e            path;
  logic [SHAMT_W-1:0]      shamt;
  logic [SGL_FRAC_W-1:0]   denorm_frac;
  logic [SGL_W-1:0]        packed_word;

  logic                    valid_d;
  logic                    valid_q;
  logic                    load_en;
  logic [SGL_W-1:0]        sgl_q;

  assign fields = dbl_fields_t'(in_dbl);

  fpn_path_decode u_decode (
    .exp_in (fields.exp),
    .path   (path),
    .shamt  (shamt)
  );

  fpn_rshift #(
    .IN_W  (MANT_W),
    .AMT_W (SHAMT_W),
    .OUT_W (SGL_FRAC_W)
  ) u_shift (
    .din  ({1'b1, fields.frac}),
    .amt  (shamt),
    .dout (denorm_frac)
  );

  fpn_pack u_pack (
    .fields      (fields),
    .path        (path),
    .denorm_frac (denorm_frac),
    .word        (packed_word)
  );

  // Next-state
  always_comb begin
    valid_d = in_valid;
    load_en = in_valid;
  end

  // Strobe register with asynchronous reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  // Data register with clock enable, no reset
  always_ff @(posedge clk) begin
    if (load_en) sgl_q <= packed_word;
  end

  assign out_valid = valid_q;
  assign out_sgl   = sgl_q;

endmodule

// File: rtl/dp_to_sp_narrow_chk.sv
module dp_to_sp_narrow_chk
  import fpn_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  sign_in,
  input logic [DBL_EXP_W-1:0]  exp_in,
  input logic [SGL_FRAC_W-1:0] top_frac,
  input logic                  out_valid,
  input logic [SGL_W-1:0]      out_sgl
);

  localparam logic [DBL_EXP_W-1:0] E_NORM  = DBL_EXP_W'(NORM_FLOOR);
  localparam logic [DBL_EXP_W-1:0] E_DEN   = DBL_EXP_W'(DENORM_FLOOR);

  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_q <= 1'b0;
    else if (in_valid) seen_q <= 1'b1;
  end

  AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid)); // R1

  AST_NORMAL_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && exp_in > E_NORM) |=>
      out_sgl == {$past(sign_in), $past(exp_in[DBL_EXP_W-1]),
                  $past(exp_in[SGL_EXP_W-2:0]), $past(top_frac)}); // R2

  AST_SPECIAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && exp_in == '1) |=> out_sgl[SGL_W-2 -: SGL_EXP_W] == '1); // R3

  AST_SMALL_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && exp_in <= E_NORM) |=>
      (out_sgl[SGL_W-1] == $past(sign_in) && out_sgl[SGL_W-2 -: SGL_EXP_W] == '0)); // R4

  AST_DENORM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && exp_in == E_NORM) |=> out_sgl[SGL_FRAC_W-1]); // R4

  AST_UNDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && exp_in < E_DEN) |=> out_sgl[SGL_W-2:0] == '0); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !in_valid) |=> $stable(out_sgl)); // R7

endmodule

bind dp_to_sp_narrow dp_to_sp_narrow_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .sign_in   (in_dbl[63]),
  .exp_in    (in_dbl[62:52]),
  .top_frac  (in_dbl[51:29]),
  .out_valid (out_valid),
  .out_sgl   (out_sgl)
);

// File: tb/dp_to_sp_narrow_tb.sv
module dp_to_sp_narrow_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_dbl;
  logic        out_valid;
  logic [31:0] out_sgl;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic [31:0] exp_q[$];
  logic [31:0] last_word;
  bit          have_last = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_to_sp_narrow u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_dbl    (in_dbl),
    .out_valid (out_valid),
    .out_sgl   (out_sgl)
  );

  // Behavioural reference of the narrowing rule
  function automatic logic [31:0] narrow_ref(logic [63:0] d);
    int e;
    longint unsigned m;
    logic [31:0] r;
    e = int'(d[62:52]);
    if (e > 896) begin
      r = {d[63:62], d[58:29]};
    end else if (e >= 874) begin
      m = (64'd1 << 52) | {12'd0, d[51:0]};
      m = m >> (926 - e);
      r = {d[63], 8'd0, m[22:0]};
    end else begin
      r = {d[63], 31'd0};
    end
    return r;
  endfunction

  // Behavioural load-side widening of a single word
  function automatic logic [63:0] widen(logic [31:0] w);
    logic [63:0] d;
    logic [63:0] t;
    int p;
    d = '0;
    d[63] = w[31];
    if (w[30:23] != 8'd0) begin
      d = {w[31:30], {3{~w[30]}}, w[29:0], 29'd0};
    end else if (w[22:0] != 23'd0) begin
      p = 0;
      for (int i = 0; i < 23; i++) if (w[i]) p = i;
      d[62:52] = 11'(p + 874);
      t = 64'(w[22:0]) << (52 - p);
      d[51:0] = t[51:0];
    end
    return d;
  endfunction

  function automatic logic [63:0] mk(logic s, int e, logic [51:0] f);
    return {s, 11'(e), f};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // One clock: drive at the falling edge, sample at the next falling edge.
  task automatic step(input logic v, input logic [63:0] d, input logic [31:0] expw,
                      input string req);
    logic [31:0] e;
    in_valid = v;
    in_dbl   = d;
    if (v) exp_q.push_back(expw);
    @(posedge clk);
    @(negedge clk);
    check(out_valid == v, "R1", {31'd0, out_valid}, {31'd0, v});
    if (v) begin
      e = exp_q.pop_front();
      check(out_sgl === e, req, out_sgl, e);
      last_word = e;
      have_last = 1;
    end else if (have_last) begin
      check(out_sgl === last_word, "R7", out_sgl, last_word);
    end
  endtask

  task automatic narrow(input logic [63:0] d, input string req);
    step(1'b1, d, narrow_ref(d), req);
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [22:0] fr [4];
    rst_n    = 1'b0;
    in_valid = 1'b1;
    in_dbl   = 64'h3FF0_0000_0000_0000;
    repeat (3) @(negedge clk);
    // R1: reset holds the strobe low even with in_valid high
    check(out_valid == 1'b0, "R1", {31'd0, out_valid}, 32'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", {31'd0, out_valid}, 32'd0);

    // R2: bit selection path
    step(1'b1, 64'h3FF0_0000_0000_0000, 32'h3F80_0000, "R2");
    step(1'b1, 64'hBFCC_3611_4000_0000, 32'hBE61_B08A, "R2");
    step(1'b1, mk(1'b0, 897, 52'd0),    32'h0080_0000, "R2");
    // R3: specials and over-range follow the same selection
    step(1'b1, 64'h7FF0_0000_0000_0000, 32'h7F80_0000, "R3");
    step(1'b1, 64'h7FF0_0000_0000_0001, 32'h7F80_0000, "R3");
    step(1'b1, 64'hFFF8_0000_0000_0000, 32'hFFC0_0000, "R3");
    narrow(mk(1'b0, 1151, 52'hA_5A5A_5A5A_5A5A), "R3");
    // R4: denormal window edges
    step(1'b1, mk(1'b0, 896, 52'd0), 32'h0040_0000, "R4");
    step(1'b1, mk(1'b1, 896, 52'd0), 32'h8040_0000, "R4");
    step(1'b1, mk(1'b0, 874, 52'd0), 32'h0000_0001, "R4");
    step(1'b1, mk(1'b1, 874, 52'hF_FFFF_FFFF_FFFF), 32'h8000_0001, "R4");
    narrow(mk(1'b0, 885, 52'h3_1234_5678_9ABC), "R4");
    // R5: below the window
    step(1'b1, mk(1'b0, 873, 52'hF_FFFF_FFFF_FFFF), 32'h0000_0000, "R5");
    step(1'b1, 64'h8000_0000_0000_0000, 32'h8000_0000, "R5");
    step(1'b1, 64'h0000_0000_0000_0000, 32'h0000_0000, "R5");
    // R6: dropped bits never round
    step(1'b1, 64'h3FF0_0000_1FFF_FFFF, 32'h3F80_0000, "R6");
    step(1'b1, mk(1'b0, 880, 52'hF_FFFF_FFFF_FFFF), 32'h0000_007F, "R6");
    // R7: idle cycles with changing data leave the output alone
    step(1'b0, 64'h7FF0_0000_0000_0000, 32'd0, "R7");
    step(1'b0, 64'h0000_0000_0000_0001, 32'd0, "R7");

    // Every exponent with random fractions and signs
    for (int e = 0; e < 2048; e++) begin
      narrow(mk(1'($urandom), e, {20'($urandom), $urandom}),
             (e > 896) ? "R2" : (e >= 874) ? "R4" : "R5");
    end

    // R8: widen then narrow returns the original word
    fr[0] = 23'd0;
    fr[1] = 23'd1;
    fr[2] = 23'h7F_FFFF;
    for (int s = 0; s < 2; s++) begin
      for (int e = 0; e < 256; e++) begin
        fr[3] = 23'($urandom);
        for (int k = 0; k < 4; k++) begin
          w = {1'(s), 8'(e), fr[k]};
          step(1'b1, widen(w), w, "R8");
        end
      end
      for (int p = 0; p < 23; p++) begin
        w = {1'(s), 8'd0, 23'(1 << p)};
        step(1'b1, widen(w), w, "R8");
      end
    end

    step(1'b0, 64'd0, 32'd0, "R7");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule